// File: doc/BRIEF.md
# Port A Register Interface with Address Decode

This block sits on the control-side port of a two-way FIFO pair and turns a processor-style control set into per-resource actions. The control set is an active-low chip select, a three-bit address, a read/write level, an active-low transfer enable and an active-low output enable, all sampled on the port clock. The address picks one of six resources: the FIFO data path, the bypass data path, or one of four flag-offset registers. The four registers hold the almost-empty and almost-full thresholds for each of the two directions.

For FIFO and bypass accesses the block produces single-cycle write and read strobes. The surrounding memories and bypass registers act on these strobes, and the block returns their read data on the bus. The offset registers live inside the block. They are loaded from the low bits of the bus on a qualifying write edge, and their contents are returned zero-extended on reads. A drive-enable output tells the pad logic when to drive the bus. When it is low the bus is left floating and the data output is held at zero.

A three-state mode machine tracks which data path the controller has selected: ST_DESELECT, ST_FIFO or ST_BYPASS. Its bypass indication is meant for re-synchronisation into the other port's clock domain. The transitions are:
- T_DROP: chip select high, from any state to ST_DESELECT.
- T_ENTER_FIFO: address 000 with chip select low, to ST_FIFO.
- T_ENTER_BYP: address 001 with chip select low, to ST_BYPASS.
- T_HOLD: any other address with chip select low keeps the current state.

Top module: `pa_regif`

## Requirements
- R1: After reset all four offset registers hold OFF_RST (default 8) and `byp_active` is 0.
- R2: `fifo_wr_stb` is 1 exactly when `pa_cs_n`=0, `pa_en_n`=0, `pa_addr`=000 and `pa_rd`=0. `fifo_rd_stb` is 1 under the same conditions with `pa_rd`=1. A driven read at 000 returns `fifo_rdata`.
- R3: `byp_wr_stb` and `byp_rd_stb` follow the same rule at `pa_addr`=001. A driven read at 001 returns `byp_rdata`.
- R4: On a rising edge with `pa_cs_n`=0, `pa_en_n`=0 and `pa_rd`=0, the register selected by the address loads `pa_din[OW-1:0]`. The mapping is: 100 A-to-B almost-empty, 101 A-to-B almost-full, 110 B-to-A almost-empty, 111 B-to-A almost-full.
- R5: An offset register is unchanged on any edge that is not a qualifying write to its own address (chip select high, enable high, read, or another address).
- R6: A driven read at an address 1xx returns the selected offset register zero-extended to DW bits, whatever the enable level.
- R7: Addresses 010 and 011 raise no strobe, change no register, and a driven read there returns zero.
- R8: `pa_dout_oe` = 1 exactly when `pa_cs_n`=0, `pa_oe_n`=0 and `pa_rd`=1. While it is 0, `pa_dout` is zero.
- R9: `byp_active` becomes 1 after the rising edge where `pa_cs_n`=0 and `pa_addr`=001. It becomes 0 after an edge where `pa_cs_n`=1 or `pa_addr`=000.
- R10: With `pa_cs_n`=0 and an address of 010 to 111, `byp_active` keeps its value across the edge.
- R11: `wr_data` always equals `pa_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_cs_n | input | 1 | Chip select, active low |
| pa_addr | input | 3 | Resource address |
| pa_rd | input | 1 | 1 = read, 0 = write |
| pa_en_n | input | 1 | Transfer enable, active low |
| pa_oe_n | input | 1 | Output enable, active low |
| pa_din | input | DW | Bus data from the controller |
| fifo_rdata | input | DW | FIFO output register contents |
| byp_rdata | input | DW | Bypass register contents toward port A |
| pa_dout | output | DW | Read data toward the bus |
| pa_dout_oe | output | 1 | Bus drive enable |
| wr_data | output | DW | Write data to FIFO and bypass input registers |
| fifo_wr_stb | output | 1 | FIFO write strobe |
| fifo_rd_stb | output | 1 | FIFO read strobe |
| byp_wr_stb | output | 1 | Bypass write strobe |
| byp_rd_stb | output | 1 | Bypass read strobe |
| byp_active | output | 1 | Bypass mode indication |
| ab_ae_off | output | OW | A-to-B almost-empty offset |
| ab_af_off | output | OW | A-to-B almost-full offset |
| ba_ae_off | output | OW | B-to-A almost-empty offset |
| ba_af_off | output | OW | B-to-A almost-full offset |

## Verification
Strobes, `pa_dout_oe`, `pa_dout` and `wr_data` are combinational in the current inputs and the current register state, so they are due in the same cycle as the stimulus. The bench changes inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. The offset registers and `byp_active` pass through one register stage and are due just after the next rising edge; the bench samples them 1 ns after that edge. It updates its arithmetic model between the two samples, so every read sees the value that was committed on the edge before.

// File: rtl/pa_regif_pkg.sv
package pa_regif_pkg;

    typedef enum logic [1:0] {
        ST_DESELECT = 2'd0,
        ST_FIFO     = 2'd1,
        ST_BYPASS   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        RES_FIFO = 2'd0,
        RES_BYP  = 2'd1,
        RES_NOP  = 2'd2,
        RES_OFF  = 2'd3
    } res_e;

    localparam int N_OFF = 4;

    function automatic res_e decode_res(input logic [2:0] a);
        res_e r;
        if (a[2])
            r = RES_OFF;
        else if (a[1])
            r = RES_NOP;
        else if (a[0])
            r = RES_BYP;
        else
            r = RES_FIFO;
        return r;
    endfunction

endpackage

// File: rtl/pa_addr_decode.sv
module pa_addr_decode
    import pa_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [2:0] addr,
    input  logic       rd,
    input  logic       en_n,
    input  logic       oe_n,
    output res_e       rsel,
    output logic [1:0] off_idx,
    output logic [N_OFF-1:0] off_wr,
    output logic       fifo_wr,
    output logic       fifo_rd,
    output logic       byp_wr,
    output logic       byp_rd,
    output logic       drive
);

    logic sel;
    logic xfer;

    always_comb begin
        sel     = !cs_n;
        xfer    = sel && !en_n;
        rsel    = decode_res(addr);
        off_idx = addr[1:0];
        off_wr  = '0;
        fifo_wr = 1'b0;
        fifo_rd = 1'b0;
        byp_wr  = 1'b0;
        byp_rd  = 1'b0;
        unique case (rsel)
            RES_FIFO: begin
                fifo_wr = xfer && !rd;
                fifo_rd = xfer && rd;
            end
            RES_BYP: begin
                byp_wr = xfer && !rd;
                byp_rd = xfer && rd;
            end
            RES_OFF: begin
                off_wr[off_idx] = xfer && !rd;
            end
            RES_NOP: begin
            end
        endcase
        drive = sel && !oe_n && rd;
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, fifo_rd, byp_wr, byp_rd, off_wr})) // R2
        else $error("more than one strobe active");

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2:1] == 2'b01) |-> ({fifo_wr, fifo_rd, byp_wr, byp_rd, off_wr} == '0)) // R7
        else $error("strobe raised at a no-operation address");

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!drive && ({fifo_wr, fifo_rd, byp_wr, byp_rd, off_wr} == '0))) // R8
        else $error("activity while chip select high");

endmodule

// File: rtl/pa_offset_bank.sv
module pa_offset_bank
    import pa_regif_pkg::*;
#(
    parameter int OW      = 9,
    parameter int OFF_RST = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_OFF-1:0]          wr_en,
    input  logic [OW-1:0]             wdata,
    output logic [N_OFF-1:0][OW-1:0]  regs
);

    localparam logic [OW-1:0] RST_V = OW'(OFF_RST);

    for (genvar g = 0; g < N_OFF; g++) begin : g_off
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= RST_V;
            else if (wr_en[g])
                regs[g] <= wdata;
        end

        AST_OFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> (regs[g] == $past(wdata))) // R4
            else $error("offset register did not load");

        AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(regs[g])) // R5
            else $error("offset register changed without a write");
    end

endmodule

// File: rtl/pa_mode_fsm.sv
module pa_mode_fsm
    import pa_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [2:0] addr,
    output logic       byp_active
);

    mode_e st_q;
    mode_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_DESELECT;
        else
            st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        if (cs_n) begin
            st_nxt = ST_DESELECT;              // T_DROP
        end else begin
            unique case (addr)
                3'b000:  st_nxt = ST_FIFO;     // T_ENTER_FIFO
                3'b001:  st_nxt = ST_BYPASS;   // T_ENTER_BYP
                default: st_nxt = st_q;        // T_HOLD
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            ST_BYPASS:   byp_active = 1'b1;
            ST_FIFO:     byp_active = 1'b0;
            ST_DESELECT: byp_active = 1'b0;
            default:     byp_active = 1'b0;
        endcase
    end

    AST_BYP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 3'b001) |=> byp_active) // R9
        else $error("bypass mode not entered");

    AST_BYP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || addr == 3'b000) |=> !byp_active) // R9
        else $error("bypass mode not left");

    AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr[2:1] != 2'b00) |=> (byp_active == $past(byp_active))) // R10
        else $error("bypass mode changed on an unrelated address");

endmodule

// File: rtl/pa_regif.sv
module pa_regif
    import pa_regif_pkg::*;
#(
    parameter int DW      = 18,
    parameter int OW      = 9,
    parameter int OFF_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pa_cs_n,
    input  logic [2:0]    pa_addr,
    input  logic          pa_rd,
    input  logic          pa_en_n,
    input  logic          pa_oe_n,
    input  logic [DW-1:0] pa_din,
    input  logic [DW-1:0] fifo_rdata,
    input  logic [DW-1:0] byp_rdata,
    output logic [DW-1:0] pa_dout,
    output logic          pa_dout_oe,
    output logic [DW-1:0] wr_data,
    output logic          fifo_wr_stb,
    output logic          fifo_rd_stb,
    output logic          byp_wr_stb,
    output logic          byp_rd_stb,
    output logic          byp_active,
    output logic [OW-1:0] ab_ae_off,
    output logic [OW-1:0] ab_af_off,
    output logic [OW-1:0] ba_ae_off,
    output logic [OW-1:0] ba_af_off
);

    localparam int PAD_W = DW - OW;

    res_e                     rsel;
    logic [1:0]               off_idx;
    logic [N_OFF-1:0]         off_wr;
    logic [N_OFF-1:0][OW-1:0] off_q;
    logic                     drive;

    pa_addr_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (pa_cs_n),
        .addr    (pa_addr),
        .rd      (pa_rd),
        .en_n    (pa_en_n),
        .oe_n    (pa_oe_n),
        .rsel    (rsel),
        .off_idx (off_idx),
        .off_wr  (off_wr),
        .fifo_wr (fifo_wr_stb),
        .fifo_rd (fifo_rd_stb),
        .byp_wr  (byp_wr_stb),
        .byp_rd  (byp_rd_stb),
        .drive   (drive)
    );

    pa_offset_bank #(
        .OW      (OW),
        .OFF_RST (OFF_RST)
    ) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (off_wr),
        .wdata (pa_din[OW-1:0]),
        .regs  (off_q)
    );

    pa_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (pa_cs_n),
        .addr       (pa_addr),
        .byp_active (byp_active)
    );

    // Register order follows the address low bits.
    assign ab_ae_off = off_q[0];
    assign ab_af_off = off_q[1];
    assign ba_ae_off = off_q[2];
    assign ba_af_off = off_q[3];
    assign wr_data   = pa_din;
    assign pa_dout_oe = drive;

    always_comb begin
        pa_dout = '0;
        if (drive) begin
            unique case (rsel)
                RES_FIFO: pa_dout = fifo_rdata;
                RES_BYP:  pa_dout = byp_rdata;
                RES_OFF:  pa_dout = {{PAD_W{1'b0}}, off_q[off_idx]};
                RES_NOP:  pa_dout = '0;
            endcase
        end
    end

    AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_dout_oe |-> (pa_dout == '0)) // R8
        else $error("data output not zero while undriven");

    AST_NOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_addr[2:1] == 2'b01) |-> (pa_dout == '0)) // R7
        else $error("no-operation read returned data");

endmodule

// File: tb/pa_regif_bench.sv
`timescale 1ns/1ps
module pa_regif_bench;

    localparam int DW = 18;
    localparam int OW = 9;
    localparam int OFF_RST = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pa_cs_n, pa_rd, pa_en_n, pa_oe_n;
    logic [2:0]    pa_addr;
    logic [DW-1:0] pa_din, fifo_rdata, byp_rdata;
    logic [DW-1:0] pa_dout, wr_data;
    logic          pa_dout_oe, fifo_wr_stb, fifo_rd_stb, byp_wr_stb, byp_rd_stb, byp_active;
    logic [OW-1:0] ab_ae_off, ab_af_off, ba_ae_off, ba_af_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [OW-1:0] m_off [4];
    logic          m_byp;

    always #4 clk = ~clk;

    pa_regif #(.DW(DW), .OW(OW), .OFF_RST(OFF_RST)) u_pa_regif (
        .clk(clk), .rst_n(rst_n), .pa_cs_n(pa_cs_n), .pa_addr(pa_addr),
        .pa_rd(pa_rd), .pa_en_n(pa_en_n), .pa_oe_n(pa_oe_n), .pa_din(pa_din),
        .fifo_rdata(fifo_rdata), .byp_rdata(byp_rdata), .pa_dout(pa_dout),
        .pa_dout_oe(pa_dout_oe), .wr_data(wr_data), .fifo_wr_stb(fifo_wr_stb),
        .fifo_rd_stb(fifo_rd_stb), .byp_wr_stb(byp_wr_stb), .byp_rd_stb(byp_rd_stb),
        .byp_active(byp_active), .ab_ae_off(ab_ae_off), .ab_af_off(ab_af_off),
        .ba_ae_off(ba_ae_off), .ba_af_off(ba_af_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [OW-1:0] off_out(input int k);
        case (k)
            0: return ab_ae_off;
            1: return ab_af_off;
            2: return ba_ae_off;
            default: return ba_af_off;
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        pa_cs_n = 1'b1; pa_addr = '0; pa_rd = 1'b0; pa_en_n = 1'b1; pa_oe_n = 1'b1;
        pa_din = '0; fifo_rdata = 18'h2A5C3; byp_rdata = 18'h15A3C;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < 4; k++) begin
            m_off[k] = OW'(OFF_RST);
            chk("R1 offset reset", 32'(off_out(k)), 32'(OFF_RST));
        end
        m_byp = 1'b0;
        chk("R1 bypass reset", 32'(byp_active), 32'd0);

        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 128; i++) begin
                int idx;
                logic [2:0] a;
                logic rd, en_n, cs_n, oe_n, xfer, drv, wq;
                logic [DW-1:0] d, exp_dout;
                string dreq;
                idx  = (pass == 0) ? i : 127 - i;
                a    = 3'(idx);
                rd   = idx[3];
                en_n = idx[4];
                cs_n = idx[5];
                oe_n = idx[6];
                d    = DW'(idx * 2731 + 341 + pass * 77777);

                @(negedge clk);
                pa_addr = a; pa_rd = rd; pa_en_n = en_n; pa_cs_n = cs_n;
                pa_oe_n = oe_n; pa_din = d;
                fifo_rdata = fifo_rdata ^ DW'(idx);
                byp_rdata  = byp_rdata + DW'(3);
                #1;
                xfer = !cs_n && !en_n;
                drv  = !cs_n && !oe_n && rd;
                chk("R2 fifo strobes", 32'({fifo_wr_stb, fifo_rd_stb}),
                    32'({xfer && a == 3'b000 && !rd, xfer && a == 3'b000 && rd}));
                chk(a[2:1] == 2'b01 ? "R7 bypass strobes at nop" : "R3 bypass strobes",
                    32'({byp_wr_stb, byp_rd_stb}),
                    32'({xfer && a == 3'b001 && !rd, xfer && a == 3'b001 && rd}));
                chk("R8 drive enable", 32'(pa_dout_oe), 32'(drv));
                chk("R11 write data", 32'(wr_data), 32'(d));
                if (!drv) begin
                    exp_dout = '0; dreq = "R8 undriven data";
                end else if (a == 3'b000) begin
                    exp_dout = fifo_rdata; dreq = "R2 fifo read data";
                end else if (a == 3'b001) begin
                    exp_dout = byp_rdata; dreq = "R3 bypass read data";
                end else if (!a[2]) begin
                    exp_dout = '0; dreq = "R7 nop read data";
                end else begin
                    exp_dout = DW'(m_off[a[1:0]]); dreq = "R6 offset read data";
                end
                chk(dreq, 32'(pa_dout), 32'(exp_dout));

                wq = xfer && !rd;
                if (wq && a[2]) m_off[a[1:0]] = d[OW-1:0];
                if (cs_n || a == 3'b000) m_byp = 1'b0;
                else if (a == 3'b001)    m_byp = 1'b1;

                @(posedge clk);
                #1;
                for (int k = 0; k < 4; k++) begin
                    if (wq && a[2] && a[1:0] == 2'(k))
                        chk("R4 offset load", 32'(off_out(k)), 32'(m_off[k]));
                    else if (a[2:1] == 2'b01)
                        chk("R7 offset untouched by nop", 32'(off_out(k)), 32'(m_off[k]));
                    else
                        chk("R5 offset held", 32'(off_out(k)), 32'(m_off[k]));
                end
                if (!cs_n && a[2:1] != 2'b00)
                    chk("R10 bypass hold", 32'(byp_active), 32'(m_byp));
                else
                    chk("R9 bypass enter/exit", 32'(byp_active), 32'(m_byp));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule